// File: doc/BRIEF.md
# Synchronous Master Serial Transmitter

This block drives a clock line and a data line as the master of a half-duplex synchronous serial link. A host hands it words through a single-entry holding buffer. Whenever the shift stage has nothing left to send, the buffered word moves into it in one clock cycle. The shift stage then serializes the word least significant bit first while the block produces the serial clock from a programmable divider. An optional ninth bit, supplied on its own input, can be appended after the eight data bits.

Two status flags can be polled by the host. One reports that the holding buffer can take a word. The other reports that the shift stage is idle. The holding-buffer flag clears only when a word is accepted. A word already waiting in the buffer is sent directly after the current one, with no idle clock between them. A receive-inhibit output stays high while any word is pending or on the wire, which keeps the link half-duplex. Clearing the enable returns the clock line to its idle level and discards everything pending.

Top module: `sms_tx_master`

## Requirements
- R1: While reset is high and on the cycle after it is released, `sck` equals `pol`, `sdo` is 0, `hold_empty` and `shift_empty` are 1 and `rx_inhibit` is 0.
- R2: In 8-bit mode (`nine_en`=0) exactly 8 bits are sent per word, `wr_data` bit 0 first and bit 7 last.
- R3: In 9-bit mode (`nine_en`=1) the value of `bit9` at load time is sent as the ninth and last bit after the 8 data bits.
- R4: Each serial clock half-period lasts `div`+1 cycles of `clk`, so consecutive leading clock edges within a word are 2×(`div`+1) cycles apart.
- R5: `sck` idles at the level of `pol`. A bit starts with `sck` leaving the idle level, and `sdo` changes at that point. `sdo` holds steady through the edge that returns `sck` to idle, where the receiver samples it.
- R6: A write accepted on a clock edge drives `hold_empty` to 0 after that edge. If the shift stage is empty, the next edge moves the word across: `hold_empty` returns to 1, `shift_empty` falls to 0, `sck` goes to the non-idle level and `sdo` shows bit 0.
- R7: A word waiting in the holding buffer when the last bit of the current word completes is loaded at once. The leading edges keep the spacing of R4 across the word boundary.
- R8: `hold_empty` is cleared only by an accepted write. A write while the buffer is full is ignored: the flag stays 0 and the ignored word is never sent.
- R9: `shift_empty` is 0 from the load of a word until the end of its last bit's second half-period, and 1 whenever no word is being shifted.
- R10: `rx_inhibit` is 1 whenever a word is held in the buffer or is being shifted, and 0 otherwise.
- R11: With `en` low, the edge that follows forces `hold_empty`=1, `shift_empty`=1, `rx_inhibit`=0 and `sck`=`pol`. Writes presented while `en` is low are ignored, including a write in the same cycle that `en` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the divider counts its cycles |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Transmit enable; low flushes buffer and shift stage |
| pol | input | 1 | Idle level of the serial clock line |
| nine_en | input | 1 | Select 9-bit words |
| bit9 | input | 1 | Ninth bit, captured when a word is loaded |
| div | input | DIV_W | Half-period length minus one, in `clk` cycles |
| wr_en | input | 1 | Holding-buffer write strobe |
| wr_data | input | DATA_W | Word to transmit |
| sck | output | 1 | Serial clock line |
| sdo | output | 1 | Serial data line |
| rx_inhibit | output | 1 | High while transmission is pending or active |
| hold_empty | output | 1 | Holding buffer can accept a word |
| shift_empty | output | 1 | Shift stage has nothing left to send |

## Verification
The case that needs care is a host write that lands in the same cycle in which `en` falls. The flush and the buffer load then compete for the holding register. The bench loads one word into the shift stage and a second into the buffer. On a single falling clock edge it then lowers `en` and raises `wr_en` carrying a third word. It judges the outcome at the next sample point: both flags must read empty, `sck` must sit at its idle level and `rx_inhibit` must be low. It then re-enables the block and waits long enough to show that no clock activity follows, which proves the colliding word was dropped.

// File: rtl/sms_pkg.sv
package sms_pkg;

  // half-period of the current bit: clock away from idle, then back at idle
  typedef enum logic {
    PH_LEAD  = 1'b0,
    PH_TRAIL = 1'b1
  } sms_phase_t;

endpackage

// File: rtl/sms_baud.sv
module sms_baud #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);

  logic [DIV_W-1:0] cnt;
  logic             wrap;

  assign wrap = (cnt >= div);
  assign tick = run && wrap;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
    end else if (wrap) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R4
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    run && $past(run) && $stable(div) |-> cnt <= div);

  // R4
  cnt_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !run |=> cnt == '0);

endmodule

// File: rtl/sms_hold.sv
module sms_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              take,
  output logic              full,
  output logic [DATA_W-1:0] data
);

  logic accept;

  assign accept = en && wr_en && !full;

  always_ff @(posedge clk) begin
    if (rst) begin
      full <= 1'b0;
    end else if (!en) begin
      full <= 1'b0;
    end else if (take) begin
      full <= 1'b0;
    end else if (accept) begin
      full <= 1'b1;
    end
  end

  // data register without reset so it maps onto plain flops
  always_ff @(posedge clk) begin
    if (accept) begin
      data <= wr_data;
    end
  end

  // R8
  hold_keep_chk: assert property (@(posedge clk) disable iff (rst)
    full && en && !take |=> full && $stable(data));

  // R8
  empty_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    !full && !(en && wr_en) |=> !full);

endmodule

// File: rtl/sms_shift.sv
module sms_shift
  import sms_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              pol,
  input  logic              nine_en,
  input  logic              bit9,
  input  logic              tick,
  input  logic              hold_full,
  input  logic [DATA_W-1:0] hold_data,
  output logic              take,
  output logic              active,
  output logic              sck,
  output logic              sdo
);

  localparam int FRAME_W = DATA_W + 1;
  localparam int IDX_W   = $clog2(FRAME_W);

  logic [FRAME_W-1:0] shreg;
  logic [IDX_W-1:0]   idx;
  logic [IDX_W-1:0]   idx_nx;
  logic [IDX_W-1:0]   last_idx;
  sms_phase_t         phase;
  logic               last_done;

  assign idx_nx    = idx + 1'b1;
  assign last_done = active && tick && (phase == PH_TRAIL) && (idx == last_idx);
  assign take      = en && hold_full && (!active || last_done);

  always_ff @(posedge clk) begin
    if (rst) begin
      active   <= 1'b0;
      sck      <= pol;
      sdo      <= 1'b0;
      phase    <= PH_LEAD;
      idx      <= '0;
      last_idx <= '0;
      shreg    <= '0;
    end else if (!en) begin
      active <= 1'b0;
      sck    <= pol;
      sdo    <= 1'b0;
      phase  <= PH_LEAD;
      idx    <= '0;
    end else if (take) begin
      active   <= 1'b1;
      shreg    <= {bit9, hold_data};
      sdo      <= hold_data[0];
      sck      <= ~pol;
      phase    <= PH_LEAD;
      idx      <= '0;
      last_idx <= nine_en ? IDX_W'(DATA_W) : IDX_W'(DATA_W - 1);
    end else if (last_done) begin
      active <= 1'b0;
      sck    <= pol;
      sdo    <= 1'b0;
      phase  <= PH_LEAD;
      idx    <= '0;
    end else if (active && tick) begin
      if (phase == PH_LEAD) begin
        sck   <= pol;
        phase <= PH_TRAIL;
      end else begin
        idx   <= idx_nx;
        sdo   <= shreg[idx_nx];
        sck   <= ~pol;
        phase <= PH_LEAD;
      end
    end else if (!active) begin
      sck <= pol;
    end
  end

  // R5
  sdo_hold_chk: assert property (@(posedge clk) disable iff (rst)
    active && en && tick && (phase == PH_LEAD) |=> $stable(sdo) && (sck == $past(pol)));

  // R4
  sck_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    active && en && !tick |=> $stable(sck) && $stable(sdo));

  // R7
  load_gate_chk: assert property (@(posedge clk) disable iff (rst)
    take |-> !active || (tick && phase == PH_TRAIL));

  // R5
  idle_level_chk: assert property (@(posedge clk) disable iff (rst)
    !active && !take |=> sck == $past(pol));

endmodule

// File: rtl/sms_tx_master.sv
module sms_tx_master #(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              pol,
  input  logic              nine_en,
  input  logic              bit9,
  input  logic [DIV_W-1:0]  div,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              sck,
  output logic              sdo,
  output logic              rx_inhibit,
  output logic              hold_empty,
  output logic              shift_empty
);

  logic              full;
  logic [DATA_W-1:0] hold_data;
  logic              take;
  logic              active;
  logic              tick;

  sms_hold #(.DATA_W(DATA_W)) u_hold (
    .clk     (clk),
    .rst     (rst),
    .en      (en),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .take    (take),
    .full    (full),
    .data    (hold_data)
  );

  sms_baud #(.DIV_W(DIV_W)) u_baud (
    .clk  (clk),
    .rst  (rst),
    .run  (active),
    .div  (div),
    .tick (tick)
  );

  sms_shift #(.DATA_W(DATA_W)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .pol       (pol),
    .nine_en   (nine_en),
    .bit9      (bit9),
    .tick      (tick),
    .hold_full (full),
    .hold_data (hold_data),
    .take      (take),
    .active    (active),
    .sck       (sck),
    .sdo       (sdo)
  );

  assign hold_empty  = ~full;
  assign shift_empty = ~active;
  assign rx_inhibit  = active | full;

  // R11
  flush_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> hold_empty && shift_empty && !rx_inhibit && (sck == $past(pol)));

  // R6
  move_chk: assert property (@(posedge clk) disable iff (rst)
    en && !hold_empty && shift_empty |=> hold_empty && !shift_empty);

endmodule

// File: tb/sms_tx_master_tb.sv
module sms_tx_master_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en = 1'b0;
  logic       pol = 1'b0;
  logic       nine_en = 1'b0;
  logic       bit9 = 1'b0;
  logic [7:0] div = 8'd0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'd0;
  logic       sck, sdo, rx_inhibit, hold_empty, shift_empty;

  always #4 clk = ~clk;

  sms_tx_master u_dut (
    .clk(clk), .rst(rst), .en(en), .pol(pol), .nine_en(nine_en), .bit9(bit9),
    .div(div), .wr_en(wr_en), .wr_data(wr_data), .sck(sck), .sdo(sdo),
    .rx_inhibit(rx_inhibit), .hold_empty(hold_empty), .shift_empty(shift_empty)
  );

  int total = 0;
  int bad = 0;
  int cyc = 0;

  // receiver model
  logic [31:0] rx_word;
  int rx_cnt, n_lead, gap_bad, exp_gap, last_lead;
  logic prev_sck, have_lead, broke;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (prev_sck == pol && sck != pol) begin
      if (have_lead && !broke && (cyc - last_lead) != exp_gap) gap_bad = gap_bad + 1;
      last_lead = cyc;
      have_lead = 1'b1;
      broke = 1'b0;
      n_lead = n_lead + 1;
    end
    if (prev_sck != pol && sck == pol) begin
      if (rx_cnt < 32) rx_word[rx_cnt] = sdo;
      rx_cnt = rx_cnt + 1;
    end
    if (shift_empty) broke = 1'b1;
    prev_sck = sck;
  end

  task automatic clear_mon(input int gap);
    rx_word = '0; rx_cnt = 0; n_lead = 0; gap_bad = 0;
    have_lead = 1'b0; broke = 1'b1; exp_gap = gap; last_lead = 0;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic write_word(input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (shift_empty && hold_empty) break;
    end
    repeat (2) @(negedge clk);
  endtask

  always @(posedge clk) begin
    if (cyc > 100000) begin
      total++; bad++;
      $display("FAIL watchdog act=%0d exp=done", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // {pol, nine_en, bit9, div[7:0], data[7:0]}
  localparam logic [18:0] VEC [6] = '{
    {1'b0, 1'b0, 1'b0, 8'd0, 8'hA5},
    {1'b1, 1'b0, 1'b0, 8'd1, 8'h3C},
    {1'b0, 1'b1, 1'b1, 8'd2, 8'h01},
    {1'b1, 1'b1, 1'b0, 8'd3, 8'hFF},
    {1'b0, 1'b1, 1'b1, 8'd5, 8'h80},
    {1'b1, 1'b0, 1'b0, 8'd2, 8'h5A}
  };

  initial begin
    clear_mon(2);
    prev_sck = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 sck idle in reset", {31'd0, sck}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 sck", {31'd0, sck}, 32'd0);
    chk("R1 sdo", {31'd0, sdo}, 32'd0);
    chk("R1 flags", {30'd0, hold_empty, shift_empty}, 32'd3);
    chk("R1 rx_inhibit", {31'd0, rx_inhibit}, 32'd0);

    // vector walk: R2 R3 R4 R5 R9
    en = 1'b1;
    for (int v = 0; v < 6; v++) begin
      pol = VEC[v][18]; nine_en = VEC[v][17]; bit9 = VEC[v][16]; div = VEC[v][15:8];
      repeat (3) @(negedge clk);
      chk("R5 idle level", {31'd0, sck}, {31'd0, pol});
      clear_mon(2 * (int'(div) + 1));
      write_word(VEC[v][7:0]);
      wait_idle();
      if (nine_en) begin
        chk("R3 ninth bit word", rx_word, {23'd0, bit9, VEC[v][7:0]});
        chk("R3 bit count", rx_cnt, 32'd9);
      end else begin
        chk("R2 lsb-first word", rx_word, {24'd0, VEC[v][7:0]});
        chk("R2 bit count", rx_cnt, 32'd8);
      end
      chk("R4 edge spacing", gap_bad, 32'd0);
      chk("R4 lead edges", n_lead, nine_en ? 32'd9 : 32'd8);
      chk("R9 shift_empty after word", {31'd0, shift_empty}, 32'd1);
      chk("R5 idle after word", {31'd0, sck}, {31'd0, pol});
    end

    // R6 transfer timing, R10
    pol = 1'b0; nine_en = 1'b0; div = 8'd3;
    repeat (3) @(negedge clk);
    clear_mon(8);
    @(negedge clk); wr_en = 1'b1; wr_data = 8'h97;
    @(negedge clk); wr_en = 1'b0;
    chk("R6 hold taken", {30'd0, hold_empty, shift_empty}, 32'd1);
    chk("R10 inhibit while held", {31'd0, rx_inhibit}, 32'd1);
    @(negedge clk);
    chk("R6 moved to shifter", {30'd0, hold_empty, shift_empty}, 32'd2);
    chk("R6 first bit", {30'd0, sck, sdo}, 32'd3);
    chk("R10 inhibit while shifting", {31'd0, rx_inhibit}, 32'd1);
    wait_idle();
    chk("R2 word 97", rx_word, 32'h97);
    chk("R10 inhibit released", {31'd0, rx_inhibit}, 32'd0);

    // R7 back to back at the fastest rate
    div = 8'd0; pol = 1'b1;
    repeat (3) @(negedge clk);
    clear_mon(2);
    write_word(8'hC3);
    while (!hold_empty) @(negedge clk);
    write_word(8'h5E);
    wait_idle();
    chk("R7 two words", rx_word, 32'h5EC3);
    chk("R7 no gap", gap_bad, 32'd0);
    chk("R7 lead edges", n_lead, 32'd16);

    // R8 write while full ignored
    div = 8'd4; pol = 1'b0;
    repeat (3) @(negedge clk);
    clear_mon(10);
    write_word(8'h11);
    while (!hold_empty) @(negedge clk);
    write_word(8'h22);
    chk("R8 full after write", {31'd0, hold_empty}, 32'd0);
    write_word(8'h33);
    chk("R8 still full after ignored write", {31'd0, hold_empty}, 32'd0);
    wait_idle();
    chk("R8 ignored word not sent", rx_word, 32'h2211);
    chk("R8 bit count", rx_cnt, 32'd16);

    // R11 disable mid-word
    div = 8'd3;
    write_word(8'hF0);
    repeat (5) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    chk("R11 flushed", {29'd0, hold_empty, shift_empty, rx_inhibit}, 32'd6);
    chk("R11 sck idle", {31'd0, sck}, 32'd0);

    // R11 writes ignored while disabled
    write_word(8'h44);
    chk("R11 write while disabled", {31'd0, hold_empty}, 32'd1);

    // R11 collision: enable drop with a write in the same cycle
    en = 1'b1;
    repeat (2) @(negedge clk);
    write_word(8'h66);
    while (!hold_empty) @(negedge clk);
    write_word(8'h77);
    @(negedge clk); en = 1'b0; wr_en = 1'b1; wr_data = 8'h88;
    @(negedge clk); wr_en = 1'b0;
    chk("R11 collision flags", {29'd0, hold_empty, shift_empty, rx_inhibit}, 32'd6);
    chk("R11 collision sck", {31'd0, sck}, 32'd0);
    en = 1'b1;
    repeat (20) @(negedge clk);
    chk("R11 colliding word dropped", {30'd0, hold_empty, shift_empty}, 32'd3);
    chk("R9 idle after flush", {31'd0, sck}, 32'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule